// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block makes the final pass-or-drop decision for each frame that an Ethernet receive path has collected. When the receiver signals the end of a frame, the filter combines four inputs into one decision: whether the destination was a broadcast, the outcome of the address-table lookup, the error flags gathered while the frame was on the wire, and the frame's byte count. The result is a one-cycle strobe that carries an accept bit and a 16-bit receive status word. A host-side writer uses the accept bit to keep or discard the buffered frame and copies the status word into its completion record.

The policy settings are promiscuous, broadcast rejection, pass-bad-frames, table-miss default and a two-bit maximum-length code. They are captured when a frame starts, so a change made in the middle of a frame affects only later frames. Length limits, the minimum length and the counter width are parameters. A parameter also selects whether the length check uses four parallel comparators or a single comparator fed through a multiplexer.

Top module: `rxf_accept_filter`

## Requirements
- R1: With promiscuous set, the address outcome is pass whatever the broadcast flag and lookup result are. An errored frame is still dropped unless pass-bad-frames is set.
- R2: Without promiscuous, a broadcast frame is dropped by address when reject-broadcast is 1. When reject-broadcast is 0 it passes address filtering without consulting the table result.
- R3: For a non-broadcast frame without promiscuous, when the lookup found the address, the entry's receive bit decides the address outcome (1 passes, 0 drops).
- R4: For a non-broadcast frame without promiscuous, when the lookup missed, the default-mode bit decides the address outcome (1 passes, 0 drops).
- R5: A frame with any error in status bits 0, 1, 5, 6, 7 or 8 is accepted only when pass-bad-frames is 1 and the address outcome is pass. A frame without errors is accepted exactly when the address outcome is pass.
- R6: The max-length code selects a limit of 1518 (code 0), 1536 (code 1), 2048 (code 2) or 65536 (code 3) bytes. A byte count above the selected limit sets status bit 7, and a count equal to the limit does not.
- R7: A byte count below 64 sets status bit 8, and a count of 64 does not.
- R8: Status bit 0 reports a CRC error, bit 1 a collision, bit 5 a late collision and bit 6 an overrun. Bit 15 is the OR of bits 0, 1, 5, 6, 7 and 8, and every other bit is 0.
- R9: Each cycle with end-of-frame high produces done high in exactly the following cycle, with accept and status for that frame. When done is low, accept and status are 0. End-of-frame in consecutive cycles gives done in consecutive cycles.
- R10: The configuration inputs are captured in the cycle where start-of-frame is high and used for that frame's decision. Changes after that cycle do not affect it. When start and end of frame coincide, the values present in that cycle are used.
- R11: While reset is asserted, and in the first cycle after it, done, accept and status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start of frame, one cycle |
| eof_i | input | 1 | End of frame, one cycle; frame inputs valid |
| bcast_i | input | 1 | Destination is the broadcast address |
| tbl_hit_i | input | 1 | Address-table lookup found the destination |
| tbl_rcv_i | input | 1 | Found entry's receive bit (1 receive, 0 discard) |
| err_crc_i | input | 1 | CRC error seen |
| err_col_i | input | 1 | Collision seen during reception |
| err_late_i | input | 1 | Late collision seen |
| err_ovr_i | input | 1 | Receive overrun |
| byte_cnt_i | input | CNT_W (17) | Received byte count including CRC |
| cfg_promisc_i | input | 1 | Accept any destination address |
| cfg_rej_bcast_i | input | 1 | Drop broadcast frames |
| cfg_pass_bad_i | input | 1 | Forward errored frames that pass address filtering |
| cfg_miss_pass_i | input | 1 | Outcome on table miss (1 pass, 0 drop) |
| cfg_maxlen_i | input | 2 | Maximum-length code |
| done_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted (valid with done_o) |
| status_o | output | 16 | Receive status word (valid with done_o) |

## Verification
Decision and status are due exactly one clock after the edge that samples end-of-frame. Configuration captured at start-of-frame takes effect at that same edge. The bench drives inputs on the falling edge. At each rising edge, a behavioural model updates its captured configuration and predicts done, accept and status. The next falling edge compares every output against that prediction, so each result is checked in the cycle it is due and found absent in every other cycle. Frame scenarios cover each policy branch, each length boundary, mid-frame configuration changes, coinciding start and end, and back-to-back end strobes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int ST_W      = 16;
   localparam int ERR_N     = 6;
   localparam int ST_SUM    = 15;

   // error vector order: crc, col, late, ovr, long, short
   localparam int E_CRC   = 0;
   localparam int E_COL   = 1;
   localparam int E_LATE  = 2;
   localparam int E_OVR   = 3;
   localparam int E_LONG  = 4;
   localparam int E_SHORT = 5;

   // status bit each error vector entry lands in
   localparam int ERR_POS [ERR_N] = '{0, 1, 5, 6, 7, 8};

   typedef struct packed {
      logic       promisc;
      logic       rej_bcast;
      logic       pass_bad;
      logic       miss_pass;
      logic [1:0] maxlen;
   } rxf_cfg_t;

endpackage

// File: rtl/rxf_cfg_hold.sv
module rxf_cfg_hold
   import rxf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sof_i,
   input  rxf_cfg_t live_i,
   output rxf_cfg_t eff_o
);

   rxf_cfg_t held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (sof_i) begin
         held_q <= live_i;
      end
   end

   // a frame that starts and ends in one cycle uses the live values
   assign eff_o = sof_i ? live_i : held_q;

endmodule

// File: rtl/rxf_len_chk.sv
module rxf_len_chk #(
   parameter int CNT_W        = 17,
   parameter int MIN_LEN      = 64,
   parameter int LIM0         = 1518,
   parameter int LIM1         = 1536,
   parameter int LIM2         = 2048,
   parameter int LIM3         = 65536,
   parameter bit PARALLEL_CMP = 1'b1
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [1:0]       code_i,
   output logic             too_long_o,
   output logic             too_short_o
);

   localparam int CW = (CNT_W > 17) ? CNT_W + 1 : 18;
   localparam int NLIM = 4;

   logic [CW-1:0] cnt_x;
   logic [CW-1:0] lim [NLIM];

   assign cnt_x  = CW'(cnt_i);
   assign lim[0] = CW'(LIM0);
   assign lim[1] = CW'(LIM1);
   assign lim[2] = CW'(LIM2);
   assign lim[3] = CW'(LIM3);

   assign too_short_o = cnt_x < CW'(MIN_LEN);

   generate
      if (PARALLEL_CMP) begin : g_par
         logic [NLIM-1:0] over;
         for (genvar i = 0; i < NLIM; i++) begin : g_cmp
            assign over[i] = cnt_x > lim[i];
         end
         assign too_long_o = over[code_i];
      end else begin : g_mux
         logic [CW-1:0] sel_lim;
         assign sel_lim    = lim[code_i];
         assign too_long_o = cnt_x > sel_lim;
      end
   endgenerate

endmodule

// File: rtl/rxf_policy.sv
module rxf_policy
   import rxf_pkg::*;
(
   input  rxf_cfg_t cfg_i,
   input  logic     bcast_i,
   input  logic     hit_i,
   input  logic     rcv_i,
   input  logic     err_any_i,
   output logic     addr_ok_o,
   output logic     accept_o
);

   always_comb begin
      if (cfg_i.promisc) begin
         addr_ok_o = 1'b1;
      end else if (bcast_i) begin
         addr_ok_o = !cfg_i.rej_bcast;
      end else if (hit_i) begin
         addr_ok_o = rcv_i;
      end else begin
         addr_ok_o = cfg_i.miss_pass;
      end
   end

   assign accept_o = addr_ok_o && (!err_any_i || cfg_i.pass_bad);

endmodule

// File: rtl/rxf_status_map.sv
module rxf_status_map
   import rxf_pkg::*;
(
   input  logic [ERR_N-1:0] err_i,
   output logic [ST_W-1:0]  status_o,
   output logic             err_any_o
);

   always_comb begin
      status_o = '0;
      for (int i = 0; i < ERR_N; i++) begin
         status_o[ERR_POS[i]] = err_i[i];
      end
      status_o[ST_SUM] = |err_i;
   end

   assign err_any_o = |err_i;

endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
   import rxf_pkg::*;
#(
   parameter int CNT_W        = 17,
   parameter int MIN_LEN      = 64,
   parameter int LIM0         = 1518,
   parameter int LIM1         = 1536,
   parameter int LIM2         = 2048,
   parameter int LIM3         = 65536,
   parameter bit PARALLEL_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_i,
   input  logic             eof_i,
   input  logic             bcast_i,
   input  logic             tbl_hit_i,
   input  logic             tbl_rcv_i,
   input  logic             err_crc_i,
   input  logic             err_col_i,
   input  logic             err_late_i,
   input  logic             err_ovr_i,
   input  logic [CNT_W-1:0] byte_cnt_i,
   input  logic             cfg_promisc_i,
   input  logic             cfg_rej_bcast_i,
   input  logic             cfg_pass_bad_i,
   input  logic             cfg_miss_pass_i,
   input  logic [1:0]       cfg_maxlen_i,
   output logic             done_o,
   output logic             accept_o,
   output logic [15:0]      status_o
);

   initial begin
      if (CNT_W < 8)
         $error("rxf_accept_filter: CNT_W too small");
      if (!(MIN_LEN < LIM0 && LIM0 <= LIM1 && LIM1 <= LIM2 && LIM2 <= LIM3))
         $error("rxf_accept_filter: length limits must be ordered");
   end

   rxf_cfg_t         cfg_live, cfg_eff;
   logic             too_long, too_short;
   logic [ERR_N-1:0] err_vec;
   logic [ST_W-1:0]  st_next;
   logic             err_any, addr_ok, acc_next;

   logic             done_q, acc_q;
   logic [ST_W-1:0]  st_q;

   assign cfg_live = '{promisc:   cfg_promisc_i,
                       rej_bcast: cfg_rej_bcast_i,
                       pass_bad:  cfg_pass_bad_i,
                       miss_pass: cfg_miss_pass_i,
                       maxlen:    cfg_maxlen_i};

   rxf_cfg_hold u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sof_i  (sof_i),
      .live_i (cfg_live),
      .eff_o  (cfg_eff)
   );

   rxf_len_chk #(
      .CNT_W        (CNT_W),
      .MIN_LEN      (MIN_LEN),
      .LIM0         (LIM0),
      .LIM1         (LIM1),
      .LIM2         (LIM2),
      .LIM3         (LIM3),
      .PARALLEL_CMP (PARALLEL_CMP)
   ) u_len (
      .cnt_i       (byte_cnt_i),
      .code_i      (cfg_eff.maxlen),
      .too_long_o  (too_long),
      .too_short_o (too_short)
   );

   always_comb begin
      err_vec          = '0;
      err_vec[E_CRC]   = err_crc_i;
      err_vec[E_COL]   = err_col_i;
      err_vec[E_LATE]  = err_late_i;
      err_vec[E_OVR]   = err_ovr_i;
      err_vec[E_LONG]  = too_long;
      err_vec[E_SHORT] = too_short;
   end

   rxf_status_map u_map (
      .err_i     (err_vec),
      .status_o  (st_next),
      .err_any_o (err_any)
   );

   rxf_policy u_pol (
      .cfg_i     (cfg_eff),
      .bcast_i   (bcast_i),
      .hit_i     (tbl_hit_i),
      .rcv_i     (tbl_rcv_i),
      .err_any_i (err_any),
      .addr_ok_o (addr_ok),
      .accept_o  (acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         acc_q  <= 1'b0;
         st_q   <= '0;
      end else if (eof_i) begin
         done_q <= 1'b1;
         acc_q  <= acc_next;
         st_q   <= st_next;
      end else begin
         done_q <= 1'b0;
         acc_q  <= 1'b0;
         st_q   <= '0;
      end
   end

   assign done_o   = done_q;
   assign accept_o = acc_q;
   assign status_o = st_q;

endmodule

// File: rtl/rxf_accept_filter_chk.sv
module rxf_accept_filter_chk #(
   parameter int CNT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sof_i,
   input logic             eof_i,
   input logic             err_crc_i,
   input logic             err_col_i,
   input logic             err_late_i,
   input logic             err_ovr_i,
   input logic [CNT_W-1:0] byte_cnt_i,
   input logic             cfg_promisc_i,
   input logic             cfg_pass_bad_i,
   input logic             cfg_maxlen_i,
   input logic             done_o,
   input logic             accept_o,
   input logic [15:0]      status_o
);

   logic hw_err;
   logic len_ok;
   assign hw_err = err_crc_i | err_col_i | err_late_i | err_ovr_i;
   assign len_ok = (byte_cnt_i >= CNT_W'(64)) && (byte_cnt_i <= CNT_W'(1518));

   AST_DONE_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      eof_i |=> done_o);  // R9

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!accept_o && status_o == 16'h0000));  // R9

   AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (status_o[15] == |{status_o[8:5], status_o[1:0]}));  // R8

   AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (status_o[14:9] == 6'h00 && status_o[4:2] == 3'h0));  // R8

   AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && byte_cnt_i < CNT_W'(64)) |=> status_o[8]);  // R7

   AST_PROMISC_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && sof_i && cfg_promisc_i && !hw_err && len_ok) |=> accept_o);  // R1

   AST_BAD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && sof_i && !cfg_pass_bad_i && hw_err) |=> !accept_o);  // R5

endmodule

bind rxf_accept_filter rxf_accept_filter_chk #(.CNT_W(CNT_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .sof_i          (sof_i),
   .eof_i          (eof_i),
   .err_crc_i      (err_crc_i),
   .err_col_i      (err_col_i),
   .err_late_i     (err_late_i),
   .err_ovr_i      (err_ovr_i),
   .byte_cnt_i     (byte_cnt_i),
   .cfg_promisc_i  (cfg_promisc_i),
   .cfg_pass_bad_i (cfg_pass_bad_i),
   .cfg_maxlen_i   (cfg_maxlen_i[0]),
   .done_o         (done_o),
   .accept_o       (accept_o),
   .status_o       (status_o)
);

// File: tb/rxf_accept_filter_tb.sv
`timescale 1ns/1ps
module rxf_accept_filter_tb_top;

   localparam int CW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof = 0, eof = 0, bc = 0, hit = 0, rcv = 0;
   logic          crc = 0, col = 0, late = 0, ovr = 0;
   logic [CW-1:0] cnt = '0;
   logic          c_pm = 0, c_rb = 0, c_pb = 0, c_mp = 0;
   logic [1:0]    c_ml = 2'd0;
   logic          done, acc;
   logic [15:0]   st;

   int            n_chk = 0, n_fail = 0, cyc = 0;
   string         tag = "R11";

   // reference model state
   logic          m_pm = 0, m_rb = 0, m_pb = 0, m_mp = 0;
   logic [1:0]    m_ml = 0;
   logic          x_done = 0, x_acc = 0;
   logic [15:0]   x_st = 0;

   always #4 clk = ~clk;  // 125 MHz

   rxf_accept_filter dut_i (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .eof_i(eof), .bcast_i(bc),
      .tbl_hit_i(hit), .tbl_rcv_i(rcv), .err_crc_i(crc), .err_col_i(col),
      .err_late_i(late), .err_ovr_i(ovr), .byte_cnt_i(cnt),
      .cfg_promisc_i(c_pm), .cfg_rej_bcast_i(c_rb), .cfg_pass_bad_i(c_pb),
      .cfg_miss_pass_i(c_mp), .cfg_maxlen_i(c_ml),
      .done_o(done), .accept_o(acc), .status_o(st));

   function automatic int limit_of(input logic [1:0] code);
      case (code)
         2'd0: return 1518;
         2'd1: return 1536;
         2'd2: return 2048;
         default: return 65536;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         x_done = 0; x_acc = 0; x_st = 0;
         m_pm = 0; m_rb = 0; m_pb = 0; m_mp = 0; m_ml = 0;
      end else begin
         if (sof) begin
            m_pm = c_pm; m_rb = c_rb; m_pb = c_pb; m_mp = c_mp; m_ml = c_ml;
         end
         x_done = eof; x_acc = 0; x_st = 0;
         if (eof) begin
            bit addr_pass, bad;
            int c;
            c = int'(cnt);
            x_st[0] = crc; x_st[1] = col; x_st[5] = late; x_st[6] = ovr;
            x_st[7] = (c > limit_of(m_ml));
            x_st[8] = (c < 64);
            bad = crc || col || late || ovr || x_st[7] || x_st[8];
            x_st[15] = bad;
            if (m_pm)      addr_pass = 1;
            else if (bc)   addr_pass = !m_rb;
            else if (hit)  addr_pass = rcv;
            else           addr_pass = m_mp;
            x_acc = addr_pass && (!bad || m_pb);
         end
      end
   end

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      n_chk += 3;
      if (done !== x_done) begin
         n_fail++; $display("FAIL %s/R9 done act=%0b exp=%0b", tag, done, x_done);
      end
      if (acc !== x_acc) begin
         n_fail++; $display("FAIL %s accept act=%0b exp=%0b", tag, acc, x_acc);
      end
      if (st !== x_st) begin
         n_fail++; $display("FAIL %s/R8 status act=%h exp=%h", tag, st, x_st);
      end
      if (cyc > 100000) begin
         n_fail++; $display("FAIL watchdog act=%0d exp<=100000", cyc);
         report();
      end
   end

   task automatic clr_frame;
      bc = 0; hit = 0; rcv = 0; crc = 0; col = 0; late = 0; ovr = 0; cnt = '0;
   endtask

   task automatic send(input string t, input bit b, h, r, e_crc, e_col, e_late,
                       e_ovr, input int n, input int gap, input bit flip);
      tag = t;
      @(negedge clk);
      sof = 1;
      if (gap > 0) begin
         @(negedge clk);
         sof = 0;
         if (flip) begin
            c_pm = ~c_pm; c_mp = ~c_mp; c_pb = ~c_pb; c_ml = c_ml + 2'd1;
         end
         repeat (gap - 1) @(negedge clk);
      end
      eof = 1; bc = b; hit = h; rcv = r;
      crc = e_crc; col = e_col; late = e_late; ovr = e_ovr; cnt = CW'(n);
      @(negedge clk);
      sof = 0; eof = 0; clr_frame();
      @(negedge clk);
   endtask

   task automatic set_cfg(input bit pm, rb, pb, mp, input logic [1:0] ml);
      c_pm = pm; c_rb = rb; c_pb = pb; c_mp = mp; c_ml = ml;
   endtask

   initial begin
      tag = "R11";
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      set_cfg(0, 0, 0, 0, 0);
      send("R3", 0, 1, 1, 0, 0, 0, 0, 100, 2, 0);
      send("R3", 0, 1, 0, 0, 0, 0, 0, 100, 2, 0);
      send("R4", 0, 0, 1, 0, 0, 0, 0, 200, 1, 0);
      set_cfg(0, 0, 0, 1, 0);
      send("R4", 0, 0, 0, 0, 0, 0, 0, 200, 1, 0);

      set_cfg(0, 1, 0, 1, 0);
      send("R2", 1, 1, 1, 0, 0, 0, 0, 64, 3, 0);
      set_cfg(0, 0, 0, 0, 0);
      send("R2", 1, 1, 0, 0, 0, 0, 0, 64, 3, 0);
      set_cfg(1, 1, 0, 0, 0);
      send("R1", 1, 0, 0, 0, 0, 0, 0, 500, 2, 0);
      send("R1", 0, 1, 0, 0, 0, 0, 0, 500, 2, 0);
      send("R1", 0, 0, 0, 1, 0, 0, 0, 500, 2, 0);
      set_cfg(1, 0, 1, 0, 0);
      send("R1", 0, 0, 0, 1, 0, 0, 0, 500, 2, 0);

      set_cfg(0, 0, 1, 0, 0);
      send("R5", 0, 0, 0, 0, 1, 0, 0, 300, 1, 0);
      send("R5", 0, 1, 1, 0, 1, 0, 0, 300, 1, 0);
      set_cfg(0, 0, 0, 0, 0);
      send("R5", 0, 1, 1, 0, 0, 1, 0, 300, 1, 0);
      send("R5", 0, 1, 1, 0, 0, 0, 1, 300, 1, 0);

      for (int code = 0; code < 4; code++) begin
         int lim;
         lim = limit_of(2'(code));
         set_cfg(0, 0, 0, 0, 2'(code));
         send("R6", 0, 1, 1, 0, 0, 0, 0, lim, 1, 0);
         send("R6", 0, 1, 1, 0, 0, 0, 0, lim + 1, 1, 0);
      end

      set_cfg(0, 0, 0, 0, 0);
      send("R7", 0, 1, 1, 0, 0, 0, 0, 63, 1, 0);
      send("R7", 0, 1, 1, 0, 0, 0, 0, 64, 1, 0);
      send("R7", 0, 1, 1, 0, 0, 0, 0, 0, 1, 0);

      send("R8", 0, 1, 1, 1, 0, 0, 0, 80, 1, 0);
      send("R8", 0, 1, 1, 0, 1, 0, 0, 80, 1, 0);
      send("R8", 0, 1, 1, 0, 0, 1, 0, 80, 1, 0);
      send("R8", 0, 1, 1, 0, 0, 0, 1, 80, 1, 0);
      send("R8", 0, 1, 1, 1, 1, 1, 1, 3000, 1, 0);

      set_cfg(0, 0, 0, 0, 0);
      send("R10", 0, 0, 0, 0, 0, 0, 0, 1530, 3, 1);
      send("R10", 0, 0, 0, 0, 0, 0, 0, 1530, 3, 1);
      set_cfg(1, 0, 0, 0, 0);
      send("R10", 0, 0, 0, 0, 0, 0, 0, 100, 0, 0);
      set_cfg(0, 0, 0, 0, 0);
      send("R10", 0, 0, 0, 0, 0, 0, 0, 100, 0, 0);

      tag = "R9";
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         sof = 1; eof = 1; hit = 1; rcv = k[0]; cnt = CW'(64 + k); crc = k[1];
         @(negedge clk);
      end
      sof = 0; eof = 0; clr_frame();
      repeat (3) @(negedge clk);

      tag = "R11";
      rst_n = 0;
      sof = 1; eof = 1; hit = 1; rcv = 1; cnt = CW'(100);
      repeat (2) @(negedge clk);
      sof = 0; eof = 0; clr_frame();
      rst_n = 1;
      repeat (2) @(negedge clk);

      report();
   end

endmodule